// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block turns three conditions into a clean processor reset. An external comparator reports whether the supply is good, an active-low push-button or logic input asks for a manual reset, and a second comparator reports that a monitored rail has dropped below its trip level. All three inputs are resynchronized to the block clock. While the supply is bad or the manual request is active, reset is held. Once both causes are gone, reset is held for a further hold-off period before it is released.

The hold-off is counted in units of a clock-enable tick supplied from outside, so the same block serves a 1 ms tick in the system and a one-cycle tick in simulation. Any new cause during the hold-off restarts it from the full length. The result is a minimum reset width, and switch bounce on the manual input needs no separate filter. Reset is presented in both polarities. A separate active-low power-fail warning follows the second comparator without any stretching. It lets software shut down in an orderly way.

Top module: `supply_reset_gen`

## Requirements
- R1: While the synchronized supply-good flag is low, reset is asserted (sys_rst = 1, sys_rst_n = 0). A falling supply_ok appears on the reset outputs on the third rising clock edge after the input changes, and not earlier.
- R2: Once supply_ok = 1 and man_rst_n = 1 hold steadily and tick_en is high every cycle, reset is released on rising edge HOLD_TICKS + 3 after the later of the two inputs became good. It remains asserted on every edge before that.
- R3: If supply_ok goes low during the hold-off, even for a single clock, the hold-off starts again in full. Release then comes HOLD_TICKS + 3 edges after supply_ok returns high.
- R4: man_rst_n = 0 asserts reset with the same three-edge latency as R1. After it returns high, reset is stretched exactly as in R2. Each new low pulse during the stretch restarts it.
- R5: sys_rst_n is the logical complement of sys_rst on every cycle, including during and right after the system reset.
- R6: pfail_warn_n equals the inverse of pfail_low, delayed by three rising edges. It has no stretching, and its value does not depend on the reset state.
- R7: The hold-off count advances only on cycles where tick_en = 1. With tick_en held at 0 and no cause active, reset stays asserted indefinitely. Once ticking resumes, release comes HOLD_TICKS + 1 edges later.
- R8: A synchronous high on rst asserts sys_rst and drives pfail_warn_n to 1 on the next edge. After rst falls, the block behaves as if the supply had just turned good, with release HOLD_TICKS + 3 edges after rst is sampled low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high system reset |
| tick_en | input | 1 | Clock enable marking one hold-off time unit |
| supply_ok | input | 1 | Supply-good flag from the external comparator, 1 = good |
| man_rst_n | input | 1 | Manual reset request, active low |
| pfail_low | input | 1 | Monitored rail below trip level, 1 = low |
| sys_rst_n | output | 1 | Processor reset, active low |
| sys_rst | output | 1 | Processor reset, active high |
| pfail_warn_n | output | 1 | Power-fail warning, active low |

## Verification
Every input passes through two synchronizer flops and one output register. An input change therefore reaches the outputs on the third rising edge, and the bench checks both edge two (old value) and edge three (new value). The release edge is HOLD_TICKS + 3 edges after the last cause clears, because the counter reloads once more on the edge where the synchronized cause is still seen. Each stimulus vector carries its own edge count, and every check is sampled on a falling edge after exactly that many rising edges. The bench therefore probes one edge before and one edge at each predicted transition. The tick-gating test counts HOLD_TICKS + 1 edges from resumed ticking, since the counter is already loaded when ticking resumes.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef struct packed {
    logic pfail;
    logic man_rst_n;
    logic supply_ok;
  } supv_causes_t;

  // values held by the synchronizer while in reset: supply bad, no manual
  // request, no power-fail warning
  localparam supv_causes_t SYNC_INIT = '{pfail: 1'b0, man_rst_n: 1'b1, supply_ok: 1'b0};

  function automatic int hold_cnt_width(input int ticks);
    return (ticks < 1) ? 1 : $clog2(ticks + 1);
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
  parameter int HOLD_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic cause,
  output logic hold_active
);
  import supv_pkg::*;

  localparam int CW = hold_cnt_width(HOLD_TICKS);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt;

  // any active cause or reset reloads the full period; ticks count it down
  always_ff @(posedge clk) begin
    if (rst || cause)
      cnt <= LOAD;
    else if (tick_en && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign hold_active = cause || (cnt != '0);

  assert_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD);

  assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
    cause |=> (cnt == LOAD) && hold_active);

  assert_no_tick_R7: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !cause) |=> $stable(cnt));

endmodule

// File: rtl/supv_out_stage.sv
module supv_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic hold_active,
  input  logic pfail,
  output logic rst_hi,
  output logic rst_lo_n,
  output logic warn_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_hi   <= 1'b1;
      rst_lo_n <= 1'b0;
      warn_n   <= 1'b1;
    end else begin
      rst_hi   <= hold_active;
      rst_lo_n <= ~hold_active;
      warn_n   <= ~pfail;
    end
  end

  assert_complement_R5: assert property (@(posedge clk) disable iff (rst)
    rst_lo_n != rst_hi);

endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
  parameter int HOLD_TICKS  = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic supply_ok,
  input  logic man_rst_n,
  input  logic pfail_low,
  output logic sys_rst_n,
  output logic sys_rst,
  output logic pfail_warn_n
);
  import supv_pkg::*;

  localparam int CAUSE_W = $bits(supv_causes_t);

  supv_causes_t raw_c, syn_c;
  logic         cause;
  logic         hold_active;

  assign raw_c = '{pfail: pfail_low, man_rst_n: man_rst_n, supply_ok: supply_ok};

  supv_sync #(
    .WIDTH (CAUSE_W),
    .STAGES(SYNC_STAGES),
    .INIT  (SYNC_INIT)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_c),
    .q  (syn_c)
  );

  assign cause = !syn_c.supply_ok || !syn_c.man_rst_n;

  supv_hold_timer #(
    .HOLD_TICKS(HOLD_TICKS)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .cause      (cause),
    .hold_active(hold_active)
  );

  supv_out_stage u_out (
    .clk        (clk),
    .rst        (rst),
    .hold_active(hold_active),
    .pfail      (syn_c.pfail),
    .rst_hi     (sys_rst),
    .rst_lo_n   (sys_rst_n),
    .warn_n     (pfail_warn_n)
  );

  assert_supply_low_R1: assert property (@(posedge clk) disable iff (rst)
    !syn_c.supply_ok |=> sys_rst);

  assert_manual_R4: assert property (@(posedge clk) disable iff (rst)
    !syn_c.man_rst_n |=> sys_rst && !sys_rst_n);

  assert_release_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> $past(syn_c.supply_ok) && $past(syn_c.man_rst_n));

  assert_pfail_R6: assert property (@(posedge clk) disable iff (rst)
    syn_c.pfail |=> !pfail_warn_n);

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> sys_rst && pfail_warn_n);

endmodule

// File: tb/supply_reset_gen_tb.sv
module supply_reset_gen_tb;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rst, tick_en, supply_ok, man_rst_n, pfail_low;
  logic sys_rst_n, sys_rst, pfail_warn_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  supply_reset_gen #(.HOLD_TICKS(H), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .supply_ok(supply_ok),
    .man_rst_n(man_rst_n), .pfail_low(pfail_low), .sys_rst_n(sys_rst_n),
    .sys_rst(sys_rst), .pfail_warn_n(pfail_warn_n)
  );

  typedef struct packed {
    logic       sok;
    logic       mr_n;
    logic       pf;
    logic [7:0] edges;
    logic       exp_rst;
    logic       exp_warn_n;
  } vec_t;

  localparam int NV = 20;
  // release due H+3 = 11 edges after the last cause clears
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 8'd10, 1'b1, 1'b1},  // R8/R2 one edge before release
    '{1'b1, 1'b1, 1'b0, 8'd1,  1'b0, 1'b1},  // R2 release edge
    '{1'b1, 1'b1, 1'b0, 8'd5,  1'b0, 1'b1},  // R2 stays released
    '{1'b1, 1'b1, 1'b1, 8'd3,  1'b0, 1'b0},  // R6 warning, reset unaffected
    '{1'b1, 1'b1, 1'b0, 8'd3,  1'b0, 1'b1},  // R6 no stretching
    '{1'b1, 1'b0, 1'b0, 8'd3,  1'b1, 1'b1},  // R4 manual asserts
    '{1'b1, 1'b1, 1'b0, 8'd10, 1'b1, 1'b1},  // R4 stretch
    '{1'b1, 1'b1, 1'b0, 8'd1,  1'b0, 1'b1},  // R4 release
    '{1'b0, 1'b1, 1'b0, 8'd2,  1'b0, 1'b1},  // R1 not before edge three
    '{1'b0, 1'b1, 1'b0, 8'd1,  1'b1, 1'b1},  // R1 edge three
    '{1'b0, 1'b1, 1'b1, 8'd3,  1'b1, 1'b0},  // R6 during reset
    '{1'b1, 1'b1, 1'b0, 8'd6,  1'b1, 1'b1},  // R3 inside hold-off
    '{1'b0, 1'b1, 1'b0, 8'd1,  1'b1, 1'b1},  // R3 one-cycle brownout
    '{1'b1, 1'b1, 1'b0, 8'd10, 1'b1, 1'b1},  // R3 full restart
    '{1'b1, 1'b1, 1'b0, 8'd1,  1'b0, 1'b1},  // R3 release after restart
    '{1'b1, 1'b0, 1'b0, 8'd1,  1'b0, 1'b1},  // R4 bounce low
    '{1'b1, 1'b1, 1'b0, 8'd1,  1'b0, 1'b1},  // R4 bounce high, not yet seen
    '{1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b1},  // R4 bounce registered
    '{1'b1, 1'b1, 1'b0, 8'd10, 1'b1, 1'b1},  // R4 stretch after bounce
    '{1'b1, 1'b1, 1'b0, 8'd1,  1'b0, 1'b1}   // R4 release
  };

  task automatic check_out(input logic exp_rst, input logic exp_warn_n, input string req);
    n_chk++;
    if (sys_rst !== exp_rst || sys_rst_n !== ~exp_rst || pfail_warn_n !== exp_warn_n) begin
      n_bad++;
      $display("FAIL %s: rst=%b rst_n=%b warn_n=%b expected rst=%b rst_n=%b warn_n=%b",
               req, sys_rst, sys_rst_n, pfail_warn_n, exp_rst, ~exp_rst, exp_warn_n);
    end
  endtask

  task automatic run_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    rst = 1'b1; tick_en = 1'b1; supply_ok = 1'b0; man_rst_n = 1'b1; pfail_low = 1'b0;
    @(negedge clk);
    run_edges(2);
    check_out(1'b1, 1'b1, "R8 reset state");
    check_out(1'b1, 1'b1, "R5 complement in reset");

    // table walk; first vector applied together with reset release
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      supply_ok = VECS[i].sok;
      man_rst_n = VECS[i].mr_n;
      pfail_low = VECS[i].pf;
      run_edges(int'(VECS[i].edges));
      check_out(VECS[i].exp_rst, VECS[i].exp_warn_n, $sformatf("R1-table vector %0d", i));
    end

    // R8: mid-run system reset with all inputs good
    rst = 1'b1;
    run_edges(1);
    check_out(1'b1, 1'b1, "R8 assert on next edge");
    rst = 1'b0;
    run_edges(H + 2);
    check_out(1'b1, 1'b1, "R8 held as fresh supply");
    run_edges(1);
    check_out(1'b0, 1'b1, "R8 release");

    // R7: no ticks, hold-off frozen
    tick_en = 1'b0;
    supply_ok = 1'b0;
    run_edges(3);
    check_out(1'b1, 1'b1, "R7 supply low");
    supply_ok = 1'b1;
    run_edges(30);
    check_out(1'b1, 1'b1, "R7 frozen without tick");
    tick_en = 1'b1;
    run_edges(H);
    check_out(1'b1, 1'b1, "R7 one edge before release");
    run_edges(1);
    check_out(1'b0, 1'b1, "R7 release");

    // R6: warning independent of a manual reset
    man_rst_n = 1'b0; pfail_low = 1'b1;
    run_edges(3);
    check_out(1'b1, 1'b0, "R6 with manual reset");
    pfail_low = 1'b0;
    run_edges(2);
    check_out(1'b1, 1'b0, "R6 edge two still old");
    run_edges(1);
    check_out(1'b1, 1'b1, "R6 edge three");

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion within 5000 cycles");
      finish_run();
    end
  end

endmodule